// File: doc/BRIEF.md
# FIFO Threshold Interrupt Controller

This block holds the interrupt and FIFO status logic that sits next to the transmit and receive FIFOs of a serial peripheral engine. The FIFOs themselves and the serial engine are outside it. It receives the current entry count of each FIFO and the push and pop strobes, including strobes that the FIFOs refuse. It keeps a copy of each level and compares the levels against two programmable watermarks. From these it builds five interrupt sources.

Three of the sources are error events: a push into a full transmit FIFO, a pop from an empty receive FIFO, and a frame arriving at a full receive FIFO. Each error is latched and stays set until software strobes the clear register or turns the engine enable off. The two watermark sources are level-driven. A raw status vector shows every source. A masked vector is the raw vector ANDed with a mask register. One interrupt line is the OR of the masked bits.

Each watermark register accepts only values below the FIFO depth. Software can therefore find the depth by writing rising values until one is not retained.

Top module: `fifo_thresh_irq`

## Requirements
- R1: After reset the level copies and both watermarks are zero, the mask is all ones (0x1F), every error flag is clear, the raw status is 0x01 and the interrupt line is high.
- R2: The transmit and receive level outputs show the level inputs sampled at the previous clock edge.
- R3: Status bit 0 (transmit-empty) is 1 exactly when the stored transmit level is less than or equal to the transmit watermark.
- R4: Status bit 4 (receive-full) is 1 exactly when the stored receive level is strictly greater than the receive watermark, so a watermark of N-1 fires at N entries.
- R5: A watermark write (select 0 = transmit, 1 = receive) with data below DEPTH is stored. A write with data of DEPTH or more leaves the previous value in place.
- R6: Status bit 1 (transmit-overflow) is set one cycle after a transmit push seen while the transmit level equals DEPTH. A push at a lower level does not set it.
- R7: Status bit 2 (receive-underflow) is set one cycle after a receive pop seen while the receive level is zero.
- R8: Status bit 3 (receive-overflow) is set one cycle after a receive frame arrival seen while the receive level equals DEPTH.
- R9: Error flags are sticky. A clear strobe resets all three at once, but an error event in the same cycle as the strobe leaves its own flag set.
- R10: While the engine enable is low, all error flags are cleared and held clear, and error events have no effect.
- R11: A mask write (select 2) loads the low five data bits. The masked status equals raw AND mask, and the interrupt line is high exactly when some masked bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Engine enable; low clears the error flags |
| tx_level_i | input | LVL_W | Current transmit FIFO entry count |
| rx_level_i | input | LVL_W | Current receive FIFO entry count |
| tx_push_i | input | 1 | Transmit push strobe, accepted or not |
| rx_push_i | input | 1 | Receive frame arrival strobe |
| rx_pop_i | input | 1 | Receive pop strobe, accepted or not |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 tx watermark, 1 rx watermark, 2 mask |
| wr_data_i | input | WR_W | Write data |
| clr_rd_i | input | 1 | Read strobe of the error clear register |
| tx_lvl_o | output | LVL_W | Stored transmit level |
| rx_lvl_o | output | LVL_W | Stored receive level |
| tx_thr_o | output | THR_W | Transmit watermark |
| rx_thr_o | output | THR_W | Receive watermark |
| mask_o | output | 5 | Interrupt mask |
| raw_o | output | 5 | Raw status |
| masked_o | output | 5 | Masked status |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest situation to reach is a clear strobe and a fresh error event landing in the same cycle. The two have opposite effects on the same flag, and the event must win. The stimulus first sets two other error flags, then raises the clear strobe and an overflowing transmit push on the same falling edge. A correct design reports only the transmit-overflow bit afterwards. Rejected watermark writes are also probed: after a valid value is stored, values at and far above the depth are written and the value read back must not change.

// File: rtl/fti_pkg.sv
package fti_pkg;
   localparam int NSRC    = 5;
   localparam int NERR    = 3;
   // status bit positions
   localparam int B_TXE   = 0;
   localparam int B_TXO   = 1;
   localparam int B_RXU   = 2;
   localparam int B_RXO   = 3;
   localparam int B_RXF   = 4;

   typedef enum logic [1:0] {
      SEL_TX_THR = 2'd0,
      SEL_RX_THR = 2'd1,
      SEL_MASK   = 2'd2,
      SEL_NONE   = 2'd3
   } wsel_e;
endpackage

// File: rtl/fti_thr_reg.sv
module fti_thr_reg #(
   parameter int DEPTH = 16,
   parameter int WR_W  = 16,
   localparam int THR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_stb,
   input  logic [WR_W-1:0]  wr_data,
   output logic [THR_W-1:0] thr_q
);
   logic fits;
   assign fits = (wr_data < WR_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            thr_q <= '0;
      else if (wr_stb && fits) thr_q <= wr_data[THR_W-1:0];
   end

   p_reject_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !fits) |=> $stable(thr_q));
   p_accept_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && fits) |=> (WR_W'(thr_q) == $past(wr_data)));
endmodule

// File: rtl/fti_err_bank.sv
module fti_err_bank #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         clr,
   input  logic [N-1:0] evt,
   output logic [N-1:0] flags
);
   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       flags[i] <= 1'b0;
         else if (!en)     flags[i] <= 1'b0;
         else if (evt[i])  flags[i] <= 1'b1;
         else if (clr)     flags[i] <= 1'b0;
      end

      p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && en && !clr) |=> flags[i]);
      p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (evt[i] && en) |=> flags[i]);
      p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !en |=> !flags[i]);
   end
endmodule

// File: rtl/fti_status.sv
module fti_status
   import fti_pkg::*;
#(
   parameter int LVL_W = 5,
   parameter int THR_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_wr,
   input  logic [NSRC-1:0]  mask_data,
   input  logic [LVL_W-1:0] tx_lvl,
   input  logic [LVL_W-1:0] rx_lvl,
   input  logic [THR_W-1:0] tx_thr,
   input  logic [THR_W-1:0] rx_thr,
   input  logic [NERR-1:0]  err,
   output logic [NSRC-1:0]  mask_q,
   output logic [NSRC-1:0]  raw,
   output logic [NSRC-1:0]  masked,
   output logic             irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '1;
      else if (mask_wr) mask_q <= mask_data;
   end

   always_comb begin
      raw        = '0;
      raw[B_TXE] = (tx_lvl <= LVL_W'(tx_thr));
      raw[B_TXO] = err[0];
      raw[B_RXU] = err[1];
      raw[B_RXO] = err[2];
      raw[B_RXF] = (rx_lvl > LVL_W'(rx_thr));
   end

   assign masked = raw & mask_q;
   assign irq    = |masked;

   p_mask_zero_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq);
   p_mask_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask_q == $past(mask_data)));
endmodule

// File: rtl/fifo_thresh_irq.sv
module fifo_thresh_irq
   import fti_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int WR_W  = 16,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int THR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [LVL_W-1:0] tx_level_i,
   input  logic [LVL_W-1:0] rx_level_i,
   input  logic             tx_push_i,
   input  logic             rx_push_i,
   input  logic             rx_pop_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [WR_W-1:0]  wr_data_i,
   input  logic             clr_rd_i,
   output logic [LVL_W-1:0] tx_lvl_o,
   output logic [LVL_W-1:0] rx_lvl_o,
   output logic [THR_W-1:0] tx_thr_o,
   output logic [THR_W-1:0] rx_thr_o,
   output logic [NSRC-1:0]  mask_o,
   output logic [NSRC-1:0]  raw_o,
   output logic [NSRC-1:0]  masked_o,
   output logic             irq_o
);
   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("fifo_thresh_irq: DEPTH must lie in 2..256");
   end
   if (WR_W <= THR_W || WR_W < NSRC) begin : g_bad_wr_w
      $error("fifo_thresh_irq: WR_W too narrow");
   end

   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_lvl_o <= '0;
         rx_lvl_o <= '0;
      end else begin
         tx_lvl_o <= tx_level_i;
         rx_lvl_o <= rx_level_i;
      end
   end

   wsel_e sel;
   assign sel = wsel_e'(wr_sel_i);

   logic [NERR-1:0] evt, err;
   assign evt[0] = tx_push_i && (tx_level_i == FULL_LVL);
   assign evt[1] = rx_pop_i  && (rx_level_i == '0);
   assign evt[2] = rx_push_i && (rx_level_i == FULL_LVL);

   fti_thr_reg #(.DEPTH(DEPTH), .WR_W(WR_W)) u_tx_thr (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_en_i && sel == SEL_TX_THR),
      .wr_data(wr_data_i), .thr_q(tx_thr_o));

   fti_thr_reg #(.DEPTH(DEPTH), .WR_W(WR_W)) u_rx_thr (
      .clk(clk), .rst_n(rst_n),
      .wr_stb(wr_en_i && sel == SEL_RX_THR),
      .wr_data(wr_data_i), .thr_q(rx_thr_o));

   fti_err_bank #(.N(NERR)) u_err (
      .clk(clk), .rst_n(rst_n), .en(en_i), .clr(clr_rd_i),
      .evt(evt), .flags(err));

   fti_status #(.LVL_W(LVL_W), .THR_W(THR_W)) u_stat (
      .clk(clk), .rst_n(rst_n),
      .mask_wr(wr_en_i && sel == SEL_MASK),
      .mask_data(wr_data_i[NSRC-1:0]),
      .tx_lvl(tx_lvl_o), .rx_lvl(rx_lvl_o),
      .tx_thr(tx_thr_o), .rx_thr(rx_thr_o),
      .err(err), .mask_q(mask_o), .raw(raw_o),
      .masked(masked_o), .irq(irq_o));

   p_txovf_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && tx_push_i && tx_level_i == FULL_LVL) |=> raw_o[B_TXO]);
   p_rxund_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && rx_pop_i && rx_level_i == '0) |=> raw_o[B_RXU]);
   p_rxovf_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && rx_push_i && rx_level_i == FULL_LVL) |=> raw_o[B_RXO]);
   p_level_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (tx_lvl_o == $past(tx_level_i)));
endmodule

// File: tb/sim_fifo_thresh_irq.sv
module sim_fifo_thresh_irq;
   localparam int CLK_NS = 10;
   localparam int DEPTH  = 16;
   localparam int WR_W   = 16;
   localparam int LVL_W  = $clog2(DEPTH + 1);
   localparam int THR_W  = $clog2(DEPTH);
   localparam int NV     = 7;

   // vectors: tx level, rx level, tx watermark, rx watermark, expected bit0, expected bit4
   localparam int V_TX [NV] = '{0, 1, 8, 9, 16, 15, 3};
   localparam int V_RX [NV] = '{0, 1, 8, 9, 16, 15, 0};
   localparam int V_TT [NV] = '{0, 0, 8, 8, 15, 15, 5};
   localparam int V_RT [NV] = '{0, 0, 8, 8, 15, 15, 0};
   localparam int V_TE [NV] = '{1, 0, 1, 0, 0, 1, 1};
   localparam int V_RF [NV] = '{0, 1, 0, 1, 1, 0, 0};

   logic clk = 1'b0, rst_n = 1'b0, en_i = 1'b0;
   logic [LVL_W-1:0] tx_level_i = '0, rx_level_i = '0;
   logic tx_push_i = 0, rx_push_i = 0, rx_pop_i = 0, wr_en_i = 0, clr_rd_i = 0;
   logic [1:0] wr_sel_i = 2'd3;
   logic [WR_W-1:0] wr_data_i = '0;
   logic [LVL_W-1:0] tx_lvl_o, rx_lvl_o;
   logic [THR_W-1:0] tx_thr_o, rx_thr_o;
   logic [4:0] mask_o, raw_o, masked_o;
   logic irq_o;

   int total = 0, bad = 0;
   bit finished = 0;

   always #(CLK_NS/2) clk = ~clk;

   fifo_thresh_irq #(.DEPTH(DEPTH), .WR_W(WR_W)) u0 (.*);

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input int sel, input int data);
      wr_en_i = 1; wr_sel_i = 2'(sel); wr_data_i = WR_W'(data);
      tick();
      wr_en_i = 0; wr_sel_i = 2'd3;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1; en_i = 1;
      tick();
      // R1 reset state
      chk("R1 tx_lvl", int'(tx_lvl_o), 0);
      chk("R1 tx_thr", int'(tx_thr_o), 0);
      chk("R1 rx_thr", int'(rx_thr_o), 0);
      chk("R1 mask", int'(mask_o), 5'h1F);
      chk("R1 raw", int'(raw_o), 1);
      chk("R1 irq", int'(irq_o), 1);

      // table walk: R2, R3, R4
      for (int i = 0; i < NV; i++) begin
         wr(0, V_TT[i]);
         wr(1, V_RT[i]);
         tx_level_i = LVL_W'(V_TX[i]); rx_level_i = LVL_W'(V_RX[i]);
         tick();
         chk("R2 tx level copy", int'(tx_lvl_o), V_TX[i]);
         chk("R2 rx level copy", int'(rx_lvl_o), V_RX[i]);
         chk("R3 tx-empty bit", int'(raw_o[0]), V_TE[i]);
         chk("R4 rx-full bit", int'(raw_o[4]), V_RF[i]);
      end

      // R5 watermark depth limit
      wr(0, 15);
      chk("R5 tx accept 15", int'(tx_thr_o), 15);
      wr(0, 16);
      chk("R5 tx reject 16", int'(tx_thr_o), 15);
      wr(0, 300);
      chk("R5 tx reject 300", int'(tx_thr_o), 15);
      wr(1, 3);
      wr(1, DEPTH);
      chk("R5 rx reject depth", int'(rx_thr_o), 3);

      // R6 transmit overflow
      tx_level_i = 15; tx_push_i = 1; tick(); tx_push_i = 0;
      tick();
      chk("R6 push below full", int'(raw_o[1]), 0);
      tx_level_i = 16; tx_push_i = 1; tick(); tx_push_i = 0;
      chk("R6 push at full", int'(raw_o[1]), 1);
      tick(); tick();
      chk("R9 sticky", int'(raw_o[1]), 1);
      clr_rd_i = 1; tick(); clr_rd_i = 0;
      chk("R9 clear strobe", int'(raw_o[1]), 0);

      // R7 receive underflow
      rx_level_i = 0; rx_pop_i = 1; tick(); rx_pop_i = 0;
      chk("R7 pop empty", int'(raw_o[2]), 1);
      // R8 receive overflow
      rx_level_i = 16; rx_push_i = 1; tick(); rx_push_i = 0;
      chk("R8 arrive full", int'(raw_o[3]), 1);

      // R9 clear with simultaneous event
      clr_rd_i = 1; tx_push_i = 1; tick(); clr_rd_i = 0; tx_push_i = 0;
      chk("R9 event beats clear", int'(raw_o[3:1]), 3'b001);

      // R10 disable clears and blocks
      en_i = 0; tick();
      chk("R10 disable clears", int'(raw_o[3:1]), 0);
      tx_push_i = 1; rx_push_i = 1; tick(); tx_push_i = 0; rx_push_i = 0;
      chk("R10 events ignored", int'(raw_o[3:1]), 0);
      en_i = 1;

      // R11 masking
      wr(2, 0);
      chk("R11 mask zero masked", int'(masked_o), 0);
      chk("R11 mask zero irq", int'(irq_o), 0);
      rx_push_i = 1; tick(); rx_push_i = 0;
      wr(2, 16'hFFE8);
      chk("R11 mask low bits", int'(mask_o), 5'h08);
      chk("R11 masked", int'(masked_o), 5'h08);
      chk("R11 irq", int'(irq_o), 1);
      clr_rd_i = 1; tick(); clr_rd_i = 0;
      chk("R11 irq after clear", int'(irq_o), 0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule